// File: doc/BRIEF.md
# Packed BCD Add/Subtract Unit

This block does decimal arithmetic on packed binary-coded decimal operands. Each operand holds four decimal digits, one per nibble. A width select chooses between a narrow form, which uses the low byte (two digits), and a wide form, which uses the whole 16-bit word (four digits). One of four operations is chosen per request: plain add, add with the incoming carry, plain subtract, and subtract with borrow. Subtract with borrow takes the inverted carry flag as its borrow. The unit returns the decimal result together with an updated carry flag and zero flag.

A request is a one-cycle strobe on `start`, with the operands, operation code, width select and current carry presented in the same cycle. Result, flags and a one-cycle `result_valid` pulse appear on the next clock edge. They then hold until the next strobe. Digit correction is done per nibble by a ripple chain of digit cells.

If an operand contains a non-decimal nibble (A to F), the result value is not defined. The unit still completes in the usual one cycle.

Top module: `bcd_addsub_unit`

## Requirements
- R1: With `op_sel` = 2'b00 (add), `result` is the decimal sum of `dst_operand` and `src_operand`, modulo 100 (narrow) or 10000 (wide). `carry_out` is 1 exactly when the true sum reaches 100 or 10000.
- R2: With `op_sel` = 2'b01 (add with carry), `carry_in` is added as one more unit into the R1 sum. Carry follows the same rule as R1.
- R3: With `op_sel` = 2'b10 (subtract), `result` is `dst_operand` minus `src_operand` in ten's complement. For example, narrow 00 minus 01 gives 99. `carry_out` is 1 when no borrow occurs, and 0 when the source exceeds the destination.
- R4: With `op_sel` = 2'b11 (subtract with borrow), the inverted `carry_in` is also subtracted. With `carry_in` = 1 the result equals R3. With `carry_in` = 0 it is one less. Carry follows the R3 rule.
- R5: With `word_mode` = 0, only the low two digits (bits 7:0) take part. Bits 15:8 of the result read 0. Carry is taken from digit 1. The upper operand bytes have no effect on the result or the flags.
- R6: `zero_out` is 1 exactly when every active result digit is 0. The carry has no bearing on it, so 50 + 50 narrow gives zero = 1 and carry = 1.
- R7: `result`, `carry_out` and `zero_out` update on the clock edge that samples `start` high, and `result_valid` is high for that one following cycle only. Without `start` the three outputs hold their values.
- R8: While `rst_n` is low, `result`, `carry_out`, `zero_out` and `result_valid` are all 0.
- R9: Operands with non-decimal nibbles still produce a `result_valid` pulse one cycle after `start`. With `word_mode` = 0 they still leave bits 15:8 of the result at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle operation strobe |
| op_sel | input | 2 | 00 add, 01 add with carry, 10 subtract, 11 subtract with borrow |
| word_mode | input | 1 | 1 = four digits, 0 = two digits |
| carry_in | input | 1 | Current carry flag |
| dst_operand | input | 16 | Destination operand (minuend / addend) |
| src_operand | input | 16 | Source operand (subtrahend / addend) |
| result | output | 16 | Packed BCD result |
| carry_out | output | 1 | Updated carry flag |
| zero_out | output | 1 | Updated zero flag |
| result_valid | output | 1 | High the cycle after a strobe |

## Verification
The hardest cases are those where a decimal carry or borrow has to ripple through every digit. Examples are 9999 plus 0000 with carry set, and 0000 minus 0000 with borrow pending, which must produce 0000 carry 1 and 9999 carry 0. The narrow forms of the same patterns are also hard, because the carry must come from the middle of the chain while the upper operand bytes hold random data. Uniform random digits rarely line up like this. The bench therefore drives these chains directly, then runs a long random stream of valid digits over all four operations, both widths and both carry values. Every result is compared against integer decimal arithmetic.

// File: rtl/bcd_arith_pkg.sv
package bcd_arith_pkg;
   localparam int unsigned NIBBLE_W = 4;

   typedef enum logic [1:0] {
      BCD_ADD = 2'b00,
      BCD_ADC = 2'b01,
      BCD_SUB = 2'b10,
      BCD_SBB = 2'b11
   } bcd_op_e;
endpackage

// File: rtl/bcd_digit_cell.sv
module bcd_digit_cell
   import bcd_arith_pkg::*;
(
   input  logic [NIBBLE_W-1:0] a_dig,
   input  logic [NIBBLE_W-1:0] b_dig,
   input  logic                subtract,
   input  logic                link_in,
   output logic [NIBBLE_W-1:0] d_dig,
   output logic                link_out
);
   logic [NIBBLE_W:0] raw_sum;
   logic [NIBBLE_W:0] raw_diff;

   always_comb begin
      raw_sum  = {1'b0, a_dig} + {1'b0, b_dig} + {{NIBBLE_W{1'b0}}, link_in};
      raw_diff = {1'b0, a_dig} - {1'b0, b_dig} - {{NIBBLE_W{1'b0}}, link_in};
      if (!subtract) begin
         // decimal carry when the binary digit sum passes nine
         link_out = (raw_sum > 5'd9);
         d_dig    = link_out ? (raw_sum[NIBBLE_W-1:0] + 4'd6) : raw_sum[NIBBLE_W-1:0];
      end else begin
         // sign bit of the 5-bit difference marks a borrow
         link_out = raw_diff[NIBBLE_W];
         d_dig    = link_out ? (raw_diff[NIBBLE_W-1:0] - 4'd6) : raw_diff[NIBBLE_W-1:0];
      end
   end
endmodule

// File: rtl/bcd_digit_chain.sv
module bcd_digit_chain
   import bcd_arith_pkg::*;
#(
   parameter int unsigned NUM_DIGITS = 4,
   parameter int unsigned TAP_DIGITS = 2,
   localparam int unsigned DATA_W    = NUM_DIGITS * NIBBLE_W
) (
   input  logic [DATA_W-1:0] a_vec,
   input  logic [DATA_W-1:0] b_vec,
   input  logic              subtract,
   input  logic              link_in,
   output logic [DATA_W-1:0] d_vec,
   output logic              link_full,
   output logic              link_tap
);
   logic [NUM_DIGITS:0] link;

   assign link[0] = link_in;

   for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
      bcd_digit_cell i_cell (
         .a_dig    (a_vec[g*NIBBLE_W +: NIBBLE_W]),
         .b_dig    (b_vec[g*NIBBLE_W +: NIBBLE_W]),
         .subtract (subtract),
         .link_in  (link[g]),
         .d_dig    (d_vec[g*NIBBLE_W +: NIBBLE_W]),
         .link_out (link[g+1])
      );
   end

   assign link_full = link[NUM_DIGITS];
   assign link_tap  = link[TAP_DIGITS];
endmodule

// File: rtl/bcd_addsub_unit.sv
module bcd_addsub_unit
   import bcd_arith_pkg::*;
#(
   parameter int unsigned WIDE_DIGITS   = 4,
   parameter int unsigned NARROW_DIGITS = 2,
   localparam int unsigned DATA_W       = WIDE_DIGITS * NIBBLE_W,
   localparam int unsigned NARROW_W     = NARROW_DIGITS * NIBBLE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        op_sel,
   input  logic              word_mode,
   input  logic              carry_in,
   input  logic [DATA_W-1:0] dst_operand,
   input  logic [DATA_W-1:0] src_operand,
   output logic [DATA_W-1:0] result,
   output logic              carry_out,
   output logic              zero_out,
   output logic              result_valid
);
   if (NARROW_DIGITS < 1 || NARROW_DIGITS >= WIDE_DIGITS) begin : g_bad_widths
      $error("bcd_addsub_unit: NARROW_DIGITS must be in 1..WIDE_DIGITS-1");
   end

   bcd_op_e           op;
   logic              is_sub;
   logic              chain_in;
   logic [DATA_W-1:0] chain_d;
   logic              link_full;
   logic              link_tap;
   logic              link_sel;
   logic [DATA_W-1:0] width_mask;
   logic [DATA_W-1:0] next_result;
   logic              next_carry;

   assign op     = bcd_op_e'(op_sel);
   assign is_sub = (op == BCD_SUB) || (op == BCD_SBB);

   always_comb begin
      unique case (op)
         BCD_ADD: chain_in = 1'b0;
         BCD_ADC: chain_in = carry_in;
         BCD_SUB: chain_in = 1'b0;
         BCD_SBB: chain_in = ~carry_in;
         default: chain_in = 1'b0;
      endcase
   end

   bcd_digit_chain #(
      .NUM_DIGITS (WIDE_DIGITS),
      .TAP_DIGITS (NARROW_DIGITS)
   ) i_chain (
      .a_vec     (dst_operand),
      .b_vec     (src_operand),
      .subtract  (is_sub),
      .link_in   (chain_in),
      .d_vec     (chain_d),
      .link_full (link_full),
      .link_tap  (link_tap)
   );

   for (genvar g = 0; g < WIDE_DIGITS; g++) begin : g_mask
      if (g < NARROW_DIGITS) begin : g_low
         assign width_mask[g*NIBBLE_W +: NIBBLE_W] = {NIBBLE_W{1'b1}};
      end else begin : g_high
         assign width_mask[g*NIBBLE_W +: NIBBLE_W] = {NIBBLE_W{word_mode}};
      end
   end

   assign link_sel    = word_mode ? link_full : link_tap;
   assign next_result = chain_d & width_mask;
   // carry means "no borrow" for subtraction
   assign next_carry  = is_sub ? ~link_sel : link_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result       <= '0;
         carry_out    <= 1'b0;
         zero_out     <= 1'b0;
         result_valid <= 1'b0;
      end else begin
         result_valid <= start;
         if (start) begin
            result    <= next_result;
            carry_out <= next_carry;
            zero_out  <= (next_result == '0);
         end
      end
   end
endmodule

// File: rtl/bcd_addsub_chk.sv
module bcd_addsub_chk #(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned NARROW_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              word_mode,
   input logic [DATA_W-1:0] result,
   input logic              carry_out,
   input logic              zero_out,
   input logic              result_valid
);
   p_valid_after_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> result_valid);

   p_no_valid_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> !result_valid);

   p_hold_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> ($stable(result) && $stable(carry_out) && $stable(zero_out)));

   p_narrow_upper_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !word_mode) |=> (result[DATA_W-1:NARROW_W] == '0));

   p_zero_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> (zero_out == (result == '0)));

   p_reset_quiet_r8: assert property (@(posedge clk)
      !rst_n |-> (!result_valid && result == '0 && !carry_out && !zero_out));
endmodule

bind bcd_addsub_unit bcd_addsub_chk #(
   .DATA_W   (DATA_W),
   .NARROW_W (NARROW_W)
) i_bcd_addsub_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start        (start),
   .word_mode    (word_mode),
   .result       (result),
   .carry_out    (carry_out),
   .zero_out     (zero_out),
   .result_valid (result_valid)
);

// File: tb/test_bcd_addsub_unit.sv
module test_bcd_addsub_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  op_sel = 2'b00;
   logic        word_mode = 1'b0;
   logic        carry_in = 1'b0;
   logic [15:0] dst_operand = '0;
   logic [15:0] src_operand = '0;
   logic [15:0] result;
   logic        carry_out;
   logic        zero_out;
   logic        result_valid;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   bcd_addsub_unit i_bcd_addsub_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
      .word_mode(word_mode), .carry_in(carry_in),
      .dst_operand(dst_operand), .src_operand(src_operand),
      .result(result), .carry_out(carry_out), .zero_out(zero_out),
      .result_valid(result_valid)
   );

   function automatic int to_int(logic [15:0] v, int nd);
      int acc = 0;
      for (int i = nd - 1; i >= 0; i--) acc = acc * 10 + int'(v[i*4 +: 4]);
      return acc;
   endfunction

   function automatic logic [15:0] to_bcd(int v);
      logic [15:0] r = '0;
      for (int i = 0; i < 4; i++) begin
         r[i*4 +: 4] = 4'(v % 10);
         v = v / 10;
      end
      return r;
   endfunction

   function automatic logic [15:0] rand_bcd();
      logic [15:0] r;
      for (int i = 0; i < 4; i++) r[i*4 +: 4] = 4'($urandom % 10);
      return r;
   endfunction

   // expected {result, carry, zero}
   function automatic logic [17:0] model(logic [1:0] op, logic wide, logic c,
                                         logic [15:0] d, logic [15:0] s);
      int nd  = wide ? 4 : 2;
      int lim = wide ? 10000 : 100;
      int dv  = to_int(d, nd);
      int sv  = to_int(s, nd);
      int v;
      logic cy;
      case (op)
         2'b00: v = dv + sv;
         2'b01: v = dv + sv + int'(c);
         2'b10: v = dv - sv;
         default: v = dv - sv - int'(!c);
      endcase
      if (op[1]) begin
         cy = (v >= 0);
         if (v < 0) v = v + lim;
      end else begin
         cy = (v >= lim);
         if (v >= lim) v = v - lim;
      end
      return {to_bcd(v), cy, (v == 0)};
   endfunction

   task automatic check(string req, logic [17:0] act, logic [17:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual res=%h c=%b z=%b expected res=%h c=%b z=%b",
                  req, act[17:2], act[1], act[0], exp[17:2], exp[1], exp[0]);
      end
   endtask

   task automatic run_op(string req, logic [1:0] op, logic wide, logic c,
                         logic [15:0] d, logic [15:0] s);
      logic [17:0] exp;
      exp = model(op, wide, c, d, s);
      @(negedge clk);
      op_sel = op; word_mode = wide; carry_in = c;
      dst_operand = d; src_operand = s; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(req, {result, carry_out, zero_out}, exp);
      check({req, " valid"}, {17'd0, result_valid}, 18'd1);
   endtask

   initial begin
      #(8 * 200000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [17:0] held;
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      // R8 reset state
      check("R8 reset", {result, carry_out, zero_out}, 18'd0);
      check("R8 reset valid", {17'd0, result_valid}, 18'd0);
      rst_n = 1'b1;

      // R1 add chains
      run_op("R1 add", 2'b00, 1'b1, 1'b0, 16'h1234, 16'h8766);
      run_op("R1 add overflow", 2'b00, 1'b1, 1'b1, 16'h9999, 16'h0001);
      // R2 add with carry across all digits
      run_op("R2 adc ripple", 2'b01, 1'b1, 1'b1, 16'h9999, 16'h0000);
      run_op("R2 adc", 2'b01, 1'b0, 1'b1, 16'h0045, 16'h0054);
      // R3 subtract
      run_op("R3 sub wrap", 2'b10, 1'b0, 1'b0, 16'h0000, 16'h0001);
      run_op("R3 sub", 2'b10, 1'b1, 1'b0, 16'h5000, 16'h0001);
      // R4 subtract with borrow
      run_op("R4 sbb borrow", 2'b11, 1'b1, 1'b0, 16'h0000, 16'h0000);
      run_op("R4 sbb no borrow", 2'b11, 1'b1, 1'b1, 16'h0000, 16'h0000);
      // R5 narrow, upper bytes ignored
      run_op("R5 narrow", 2'b00, 1'b0, 1'b0, 16'hA399, 16'h7F01);
      run_op("R5 narrow sub", 2'b11, 1'b0, 1'b0, 16'h5510, 16'h3310);
      // R6 zero with carry
      run_op("R6 zero", 2'b00, 1'b0, 1'b0, 16'h0050, 16'h0050);

      // R7 hold without strobe
      held = {result, carry_out, zero_out};
      @(negedge clk);
      dst_operand = 16'h1111; src_operand = 16'h2222; op_sel = 2'b01;
      @(negedge clk);
      check("R7 hold", {result, carry_out, zero_out}, held);
      check("R7 valid low", {17'd0, result_valid}, 18'd0);

      // R9 invalid digits still complete
      @(negedge clk);
      dst_operand = 16'hFAFA; src_operand = 16'hBCBC; word_mode = 1'b0;
      op_sel = 2'b01; carry_in = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R9 valid", {17'd0, result_valid}, 18'd1);
      check("R9 upper clear", {2'd0, result[15:8], 8'd0}, 18'd0);

      // random stream over all requirements R1 R2 R3 R4 R5 R6
      for (int k = 0; k < 400; k++) begin
         logic [1:0] op = 2'($urandom);
         logic       w  = 1'($urandom);
         logic       c  = 1'($urandom);
         logic [15:0] d = rand_bcd();
         logic [15:0] s = ($urandom % 8 == 0) ? d : rand_bcd();
         run_op("R1-4 random", op, w, c, d, s);
      end

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule